// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core with Byte Lanes

This block is a single-clock synchronous static RAM core for cache or buffer storage inside a larger design. Commands (chip select, write enable, address) are captured in an input register on the rising clock edge. A read returns the addressed word through an output register, one edge after the command was captured. A write uses late-write timing. The command edge takes the address. The following edge takes the write data and the two byte-lane selects, and commits them to the array.

The word is split into two 9-bit byte lanes. Lane a is bits [8:0] and lane b is bits [17:9]. Each lane has its own write select. A write whose selects are both off works as a dummy read: the array is unchanged and nothing is driven. The data port is modelled as separate buses, `wdata_i` and `rdata_o`, plus a drive flag, `rvalid_o`. When the port is not driven, `rvalid_o` is 0 and `rdata_o` is zero. This stands for high impedance.

Two asynchronous inputs override the synchronous pipeline:
- The output enable `oe_i` gates the driver at once, with no clock edge needed.
- The sleep input `sleep_i` switches the driver off, cancels any work pending in the pipeline, and blocks commands.

A three-state power machine governs command acceptance:
- ST_RUN: commands are accepted.
- ST_SLEEP: entered from ST_RUN on an edge where sleep is high.
- ST_WAKE: entered from ST_SLEEP on the first edge with sleep low.

ST_WAKE goes to ST_RUN on the next edge, or back to ST_SLEEP if sleep has risen again.

Top module: `lw_sram`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is active and right after it, `rvalid_o` is 0 and `rdata_o` is zero, and the power state is ST_RUN.
- R2: A read (cs_i=1, we_i=0) captured at edge k drives the full 18-bit word from the addressed location after edge k+1, for exactly one cycle.
- R3: A write (cs_i=1, we_i=1) captured at edge k takes `wdata_i` and `bw_i` at edge k+1. `bw_i[0]` enables lane a (bits [8:0]) and `bw_i[1]` enables lane b (bits [17:9]).
- R4: A write with only one select set changes only that lane, and the other lane of the word keeps its value.
- R5: A write with both selects clear (dummy read) leaves the array unchanged and drives nothing.
- R6: A cycle with cs_i=0 at the edge is a dead cycle. Nothing is written, whatever we_i and bw_i hold, and nothing is driven as a result.
- R7: During the data cycle of a write (between its command edge and its commit edge), `rvalid_o` is 0, even if a preceding read's data would otherwise be shown.
- R8: A read captured at the same edge that commits a write to that address returns the newly written data.
- R9: `oe_i`=0 forces `rvalid_o` to 0 and `rdata_o` to zero at once, without a clock edge. Restoring `oe_i` within the valid cycle restores the data.
- R10: `sleep_i`=1 forces the outputs off at once. At every edge where it is high, the command is ignored, a pending write is dropped and a pending read yields nothing.
- R11: After `sleep_i` falls, the first two edges ignore commands (ST_SLEEP to ST_WAKE, then ST_WAKE to ST_RUN). The third edge accepts.
- R12: Whenever `rvalid_o` is 0, `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write command when high, read when low |
| addr_i | input | AW | Word address |
| bw_i | input | LANES | Byte-lane write selects, taken one edge after the write command |
| wdata_i | input | LANES*LANE_W | Write data, taken one edge after the write command |
| oe_i | input | 1 | Asynchronous output enable, active high |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rvalid_o | output | 1 | High while the data port is driven |

## Verification
The bench builds the core with DEPTH=16, LANE_W=9 and LANES=2. With these values every location can be filled and read back in a few dozen cycles, so each byte-lane variant and the write-then-read case can be checked against fully known contents. The small depth also lets a write that was dropped by sleep be observed later by reading its location back. A behavioural model tracks pending commands, lane merges and the sleep and wake sequence, and the bench compares against it every cycle. Extra checks fall between edges to expose the asynchronous effect of output enable and sleep.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Operation held in the input register stage
    typedef enum logic [1:0] {
        OP_DEAD  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Power / command-acceptance state
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pwr_e;

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic          sleep_i,
    output op_e           op_o,
    output logic [AW-1:0] addr_o
);

    pwr_e          state_q, state_d;
    op_e           op_q, op_d;
    logic [AW-1:0] addr_q;
    logic          accept;

    // Power state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Power state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep_i)  state_d = ST_SLEEP;
            ST_SLEEP: if (!sleep_i) state_d = ST_WAKE;
            ST_WAKE:  state_d = sleep_i ? ST_SLEEP : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    assign accept = (state_q == ST_RUN) && !sleep_i;

    // Command decode
    always_comb begin
        op_d = OP_DEAD;
        if (accept && cs_i) op_d = we_i ? OP_WRITE : OP_READ;
    end

    // Input register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_DEAD;
            addr_q <= '0;
        end else begin
            op_q <= op_d;
            if (accept && cs_i) addr_q <= addr_i;
        end
    end

    assign op_o   = op_q;
    assign addr_o = addr_q;

    AST_SLEEP_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (op_q == OP_DEAD)); // R10

    AST_WAKE_IS_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |-> (op_q == OP_DEAD)); // R11

    AST_WRITE_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_WRITE) |-> $past(cs_i && we_i && !sleep_i)); // R3

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int DEPTH  = 16,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o
);

    // One storage bank per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en_i && lane_en_i[g])
                bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = bank[addr_i];
    end

endmodule

// File: rtl/lw_sram_outreg.sv
module lw_sram_outreg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_fire_i,
    input  logic         sleep_i,
    input  logic         oe_i,
    input  logic         wr_phase_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         dvalid_o
);

    logic [W-1:0] dout_q;
    logic         dv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dv_q   <= 1'b0;
        end else begin
            dv_q <= rd_fire_i && !sleep_i;
            if (rd_fire_i && !sleep_i) dout_q <= din_i;
        end
    end

    // Asynchronous driver gate
    assign dvalid_o = dv_q && oe_i && !sleep_i && !wr_phase_i;
    assign dout_o   = dvalid_o ? dout_q : '0;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LANES-1:0] bw_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             oe_i,
    input  logic             sleep_i,
    output logic [W-1:0]     rdata_o,
    output logic             rvalid_o
);

    op_e           op;
    logic [AW-1:0] op_addr;
    logic [W-1:0]  arr_rdata;
    logic          commit;

    lw_sram_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .sleep_i (sleep_i),
        .op_o    (op),
        .addr_o  (op_addr)
    );

    assign commit = (op == OP_WRITE) && !sleep_i;

    lw_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .wr_en_i   (commit),
        .lane_en_i (bw_i),
        .addr_i    (op_addr),
        .wdata_i   (wdata_i),
        .rdata_o   (arr_rdata)
    );

    lw_sram_outreg #(.W(W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire_i  (op == OP_READ),
        .sleep_i    (sleep_i),
        .oe_i       (oe_i),
        .wr_phase_i (op == OP_WRITE),
        .din_i      (arr_rdata),
        .dout_o     (rdata_o),
        .dvalid_o   (rvalid_o)
    );

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> $past(op == OP_READ)); // R2

    AST_WRITE_HIDES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |-> !rvalid_o); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0)); // R12

endmodule

// File: tb/test_lw_sram.sv
module test_lw_sram;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int NL    = 2;
    localparam int W     = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, we = 1'b0, oe = 1'b1, slp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw = '0;
    logic [W-1:0]  wd = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;

    always #10 clk = ~clk;

    lw_sram #(.DEPTH(DEPTH), .LANE_W(9), .LANES(NL)) i_lw_sram (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
        .bw_i(bw), .wdata_i(wd), .oe_i(oe), .sleep_i(slp),
        .rdata_o(rdata), .rvalid_o(rvalid)
    );

    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    logic [W-1:0]  hold_d = '0;
    logic [NL-1:0] hold_b = '0;

    // Behavioural reference model: kind 0 dead, 1 read, 2 write; state 0 run, 1 sleep, 2 wake
    logic [W-1:0] m_mem [DEPTH];
    int           m_kind, m_addr, m_st;
    bit           m_dv, m_acc;
    logic [W-1:0] m_dout;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_kind = 0; m_addr = 0; m_st = 0; m_dv = 0; m_dout = '0;
        end else begin
            m_acc = (m_st == 0) && !slp;
            m_dv  = (m_kind == 1) && !slp;
            if (m_kind == 1 && !slp) m_dout = m_mem[m_addr];
            if (m_kind == 2 && !slp) begin
                if (bw[0]) m_mem[m_addr][8:0]  = wd[8:0];
                if (bw[1]) m_mem[m_addr][17:9] = wd[17:9];
            end
            case (m_st)
                0:       if (slp)  m_st = 1;
                1:       if (!slp) m_st = 2;
                default: m_st = slp ? 1 : 0;
            endcase
            if (m_acc && cs) begin
                m_kind = we ? 2 : 1;
                m_addr = int'(addr);
            end else begin
                m_kind = 0;
            end
        end
    end

    task automatic check(input bit ok, input logic [W:0] act, input logic [W:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual={v,d}=%h expected=%h at %0t", cur_req, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic         ev;
            logic [W-1:0] ed;
            ev = m_dv && oe && !slp && (m_kind != 2);
            ed = ev ? m_dout : '0;
            check((rvalid === ev) && (rdata === ed), {rvalid, rdata}, {ev, ed});
        end
    end

    task automatic step(input bit c, input bit w, input int a,
                        input logic [W-1:0] nd, input logic [NL-1:0] nb);
        @(negedge clk);
        cs = c; we = w; addr = a[AW-1:0];
        wd = hold_d; bw = hold_b;
        hold_d = nd; hold_b = nb;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check(!rvalid && rdata == '0, {rvalid, rdata}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rvalid && rdata == '0, {rvalid, rdata}, '0);

        cur_req = "R3";   // fill every word, both lanes
        for (int i = 0; i < DEPTH; i++) step(1, 1, i, W'((i * 'h0a5b3) ^ 'h15a5a), 2'b11);
        idle(1);
        cur_req = "R2";   // back-to-back reads
        for (int i = 0; i < DEPTH; i++) step(1, 0, i, '0, '0);
        idle(2);

        cur_req = "R4";   // lane a only, then lane b only
        step(1, 1, 3, 18'h3ffff, 2'b01); idle(1); step(1, 0, 3, '0, '0); idle(2);
        step(1, 1, 4, 18'h00000, 2'b10); idle(1); step(1, 0, 4, '0, '0); idle(2);

        cur_req = "R5";   // dummy read: no lane selected
        step(1, 1, 5, 18'h2aaaa, 2'b00); idle(1); step(1, 0, 5, '0, '0); idle(2);

        cur_req = "R6";   // deselected write attempt
        step(0, 1, 6, 18'h11111, 2'b11); idle(1); step(1, 0, 6, '0, '0); idle(2);

        cur_req = "R7";   // read then write immediately: write data cycle hides read result
        step(1, 0, 7, '0, '0); step(1, 1, 8, 18'h0beef, 2'b11); idle(1);
        step(1, 0, 8, '0, '0); idle(2);

        cur_req = "R8";   // write then read same address back-to-back
        step(1, 1, 9, 18'h1c0de, 2'b11); step(1, 0, 9, '0, '0); idle(2);

        cur_req = "R9";   // asynchronous output enable
        step(1, 0, 10, '0, '0); idle(1);
        @(posedge clk); #7;
        oe = 1'b0; #1;
        check(!rvalid && rdata == '0, {rvalid, rdata}, '0);
        oe = 1'b1; #1;
        check(rvalid && rdata == m_mem[10], {rvalid, rdata}, {1'b1, m_mem[10]});
        step(1, 0, 11, '0, '0);
        oe = 1'b0; idle(2); oe = 1'b1; idle(1);

        cur_req = "R10";  // sleep cuts off output at once
        step(1, 0, 13, '0, '0); idle(1);
        @(posedge clk); #7;
        slp = 1'b1; #1;
        check(!rvalid && rdata == '0, {rvalid, rdata}, '0);
        idle(1);
        slp = 1'b0; idle(2);
        // pending write dropped by sleep at its commit edge
        step(1, 1, 12, 18'h3c3c3, 2'b11);
        step(0, 0, 0, '0, '0);
        slp = 1'b1;
        step(1, 0, 0, '0, '0); step(1, 1, 1, 18'h00001, 2'b11);

        cur_req = "R11";  // wake sequence: two ignored edges
        @(negedge clk); slp = 1'b0; cs = 1'b1; we = 1'b0; addr = 4'd1;
        step(1, 0, 2, '0, '0); step(1, 0, 14, '0, '0); idle(2);
        cur_req = "R10";
        step(1, 0, 12, '0, '0); step(1, 0, 1, '0, '0); idle(3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL %s watchdog expired actual=hung expected=done", cur_req);
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule